// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 46-bit virtual address into a 32-bit physical address by reading a three-deep tree of translation tables kept in memory. A request carries the virtual address. The walker also samples a root frame number, which is the physical page holding the top-level table. It then fetches one 32-bit entry per level over a single-outstanding memory read port. The walk ends with either a translated address or a fault that names the level where the chain broke.

Pages are 8 KB, so the low 13 bits of the virtual address pass straight through to the physical address. Each table page holds 2048 four-byte entries. The 33 bits above the offset therefore split into three 11-bit indices. Every entry uses the same layout: a valid flag in the lowest bit and a 19-bit frame number in the top bits. For the first two levels that frame names the next table page. For the last level it names the data page. The block is meant to sit behind a translation cache and be asked only on a miss.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset the walker is idle: `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The level-1 index is vaddr[45:35], the level-2 index is vaddr[34:24] and the level-3 index is vaddr[23:13]. Each read address equals (table frame << 13) + index * 4. The level-1 table frame is `root_frame` as sampled when the request is accepted.
- R3: An entry is valid when bit 0 is 1. Its frame number is bits [31:13]. Bits [12:1] have no effect on the walk or its result.
- R4: A walk with all entries valid issues exactly three reads, in the order level 1, 2, 3. It returns `rsp_paddr` = {level-3 frame, vaddr[12:0]}.
- R5: An invalid entry at level N ends the walk. The response has `rsp_fault` = 1, `rsp_level` = N (1, 2 or 3) and `rsp_paddr` = 0, and the walker issues no further read.
- R6: At most one read is outstanding. While `mem_req_ready` is 0, `mem_req_valid` stays 1 and `mem_req_addr` stays unchanged.
- R7: `req_ready` is 1 only while idle. A `req_valid` raised during a walk is not accepted and does not change the walk in progress.
- R8: While `rsp_ready` is 0, the response is held: `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_level` stay stable. One cycle after the response is accepted, the walker is idle again.
- R9: A successful walk reports `rsp_fault` = 0 and `rsp_level` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 46 | Virtual address to translate |
| root_frame | input | 19 | Frame number of the top-level table page |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_level | output | 2 | Level of the invalid entry (1..3), 0 on success |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The bench uses all-ones indices and offset, where index * 4 reaches the top of the table page. A wrong shift or a wrong slice there would show up as an address off by a field or as a carry into the frame. It places a fault at each of the three levels and counts the reads. A walker that kept going after a bad entry would show an extra read, and one that reported a fault off by one level would give the wrong `rsp_level`. It sets the ignored entry bits [12:1] to a nonzero pattern, so a design that used them in the frame would produce the wrong address. It also holds back the memory request and the response, and pokes `req_valid` during a walk. A design that dropped or changed a stalled request, or took a second request while busy, would be caught.

// File: rtl/ptw_pkg.sv
// Shared sizing and state encoding for the page table walker.
// Assumes VA_W == OFF_W + LEVELS*IDX_W and that IDX_W + 2 <= OFF_W,
// so that one table fits within one page.
package ptw_pkg;
    localparam int VA_W      = 46;  // virtual address width
    localparam int PA_W      = 32;  // physical address width
    localparam int OFF_W     = 13;  // page offset width (8 KB pages)
    localparam int IDX_W     = 11;  // index bits per level
    localparam int LEVELS    = 3;   // table depth
    localparam int ENT_SHIFT = 2;   // log2 of the entry size in bytes

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/ptw_index_sel.sv
// Picks the table index for the current level out of the virtual address.
// Level 0 uses the most significant index field.
// Assumes lvl < LEVELS; any other value yields index 0.
module ptw_index_sel #(
    parameter int VA_W   = ptw_pkg::VA_W,
    parameter int OFF_W  = ptw_pkg::OFF_W,
    parameter int IDX_W  = ptw_pkg::IDX_W,
    parameter int LEVELS = ptw_pkg::LEVELS,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] lvl,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] field [LEVELS];

    // One slice per level; level g sits below level g-1
    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign field[g] = vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
    end

    // Select the slice named by the level counter
    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) idx = field[i];
        end
    end

    logic unused_lo;
    assign unused_lo = ^vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
// Forms the byte address of one table entry from a table frame number
// and an index. Assumes the table fits within one page.
module ptw_entry_addr #(
    parameter int PA_W      = ptw_pkg::PA_W,
    parameter int OFF_W     = ptw_pkg::OFF_W,
    parameter int IDX_W     = ptw_pkg::IDX_W,
    parameter int ENT_SHIFT = ptw_pkg::ENT_SHIFT,
    localparam int FRAME_W  = PA_W - OFF_W
) (
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [PA_W-1:0]    entry_addr
);
    logic [PA_W-1:0] page_base;
    logic [PA_W-1:0] byte_off;

    // Page base plus the scaled index
    assign page_base  = {tbl_frame, {OFF_W{1'b0}}};
    assign byte_off   = PA_W'({idx, {ENT_SHIFT{1'b0}}});
    assign entry_addr = page_base + byte_off;
endmodule

// File: rtl/ptw_walk_fsm.sv
// Sequences one walk: accept, read each level, check validity, respond.
// Assumes the memory returns exactly one response per accepted read.
module ptw_walk_fsm
    import ptw_pkg::*;
#(
    parameter int VA_W   = ptw_pkg::VA_W,
    parameter int PA_W   = ptw_pkg::PA_W,
    parameter int OFF_W  = ptw_pkg::OFF_W,
    parameter int LEVELS = ptw_pkg::LEVELS,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int RLV_W   = $clog2(LEVELS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    output logic [RLV_W-1:0]   rsp_level,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [PA_W-1:0]    mem_rsp_data,
    output logic [VA_W-1:0]    walk_vaddr,
    output logic [LVL_W-1:0]   walk_lvl,
    output logic [FRAME_W-1:0] walk_frame
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e        st;
    logic [VA_W-1:0]    va_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [FRAME_W-1:0] frame_q;
    logic [PA_W-1:0]    paddr_q;
    logic               fault_q;
    logic [RLV_W-1:0]   flvl_q;
    logic               ent_ok;
    logic [FRAME_W-1:0] ent_frame;

    // Decode the returned entry
    assign ent_ok    = mem_rsp_data[0];
    assign ent_frame = mem_rsp_data[PA_W-1:OFF_W];

    // Walk state, level counter and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            va_q    <= '0;
            lvl_q   <= '0;
            frame_q <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            flvl_q  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    frame_q <= root_frame;
                    lvl_q   <= '0;
                    st      <= ST_ISSUE;
                end
                ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (!ent_ok) begin
                        fault_q <= 1'b1;
                        flvl_q  <= RLV_W'(lvl_q) + RLV_W'(1);
                        paddr_q <= '0;
                        st      <= ST_DONE;
                    end else if (lvl_q == LAST_LVL) begin
                        fault_q <= 1'b0;
                        flvl_q  <= '0;
                        paddr_q <= {ent_frame, va_q[OFF_W-1:0]};
                        st      <= ST_DONE;
                    end else begin
                        frame_q <= ent_frame;
                        lvl_q   <= lvl_q + LVL_W'(1);
                        st      <= ST_ISSUE;
                    end
                end
                ST_DONE: if (rsp_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs follow the state
    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_ISSUE);
    assign rsp_valid     = (st == ST_DONE);
    assign rsp_paddr     = paddr_q;
    assign rsp_fault     = fault_q;
    assign rsp_level     = flvl_q;
    assign walk_vaddr    = va_q;
    assign walk_lvl      = lvl_q;
    assign walk_frame    = frame_q;

    logic unused_bits;
    assign unused_bits = ^mem_rsp_data[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
// Top of the three-level page table walker: the control FSM plus the
// index and entry-address datapath. The memory port carries one read
// at a time.
module pt_walker #(
    parameter int VA_W      = ptw_pkg::VA_W,
    parameter int PA_W      = ptw_pkg::PA_W,
    parameter int OFF_W     = ptw_pkg::OFF_W,
    parameter int IDX_W     = ptw_pkg::IDX_W,
    parameter int LEVELS    = ptw_pkg::LEVELS,
    parameter int ENT_SHIFT = ptw_pkg::ENT_SHIFT,
    localparam int FRAME_W  = PA_W - OFF_W,
    localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int RLV_W    = $clog2(LEVELS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] root_frame,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    output logic [RLV_W-1:0]   rsp_level,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PA_W-1:0]    mem_rsp_data
);
    logic [VA_W-1:0]    walk_vaddr;
    logic [LVL_W-1:0]   walk_lvl;
    logic [FRAME_W-1:0] walk_frame;
    logic [IDX_W-1:0]   cur_idx;

    ptw_walk_fsm #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_frame(root_frame),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .walk_vaddr(walk_vaddr), .walk_lvl(walk_lvl), .walk_frame(walk_frame)
    );

    ptw_index_sel #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
    ) u_idx (
        .vaddr(walk_vaddr), .lvl(walk_lvl), .idx(cur_idx)
    );

    ptw_entry_addr #(
        .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)
    ) u_addr (
        .tbl_frame(walk_frame), .idx(cur_idx), .entry_addr(mem_req_addr)
    );
endmodule

// File: rtl/ptw_checker.sv
// Protocol and result properties for pt_walker, attached by bind.
// Assumes a response arrives only for an accepted read.
module ptw_checker #(
    parameter int VA_W  = 46,
    parameter int PA_W  = 32,
    parameter int OFF_W = 13,
    parameter int RLV_W = 2,
    parameter int LEVELS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic [RLV_W-1:0] rsp_level,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid
);
    logic            was_rst;
    logic            outstanding;
    logic [VA_W-1:0] va_cap;

    // Remember that the previous cycle was a reset cycle
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Track an accepted but unanswered read and the accepted address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            va_cap      <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
            else if (mem_rsp_valid)             outstanding <= 1'b0;
            if (req_valid && req_ready)         va_cap <= req_vaddr;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (req_ready && !rsp_valid && !mem_req_valid));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid);

    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid || outstanding) |-> !req_ready);

    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_fault) && $stable(rsp_level)));

    assert_fault_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_level != '0 && rsp_level <= RLV_W'(LEVELS)
                                      && rsp_paddr == '0));

    assert_ok_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_level == '0));

    assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_cap[OFF_W-1:0]));
endmodule

bind pt_walker ptw_checker #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .RLV_W(RLV_W), .LEVELS(LEVELS)
) u_ptw_checker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pt_walker_bench.sv
// Directed bench for pt_walker with a one-cycle-latency memory model.
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [45:0] req_vaddr = '0;
    logic [18:0] root_frame = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_level;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    int nrd = 0;
    logic [31:0] rd_log [8];
    logic [31:0] mem [logic [31:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_frame(root_frame),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Memory model: answers each accepted read one cycle later
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
                rd_log[nrd % 8] <= mem_req_addr;
                nrd <= nrd + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ea(input logic [18:0] fr, input logic [10:0] ix);
        return {fr, 13'b0} + {19'b0, ix, 2'b00};
    endfunction

    // Entry with nonzero filler in bits [12:1]; these bits must not matter (R3)
    function automatic logic [31:0] pte(input logic [18:0] fr, input logic v);
        return {fr, 12'h5A3, v};
    endfunction

    // Build the three entries for one address; vm[k] is the valid bit of level k+1
    task automatic map3(input logic [45:0] va, input logic [18:0] root, f2, f3, leaf,
                        input logic [2:0] vm, output logic [31:0] a1, a2, a3);
        a1 = ea(root, va[45:35]); mem[a1] = pte(f2, vm[0]);
        a2 = ea(f2, va[34:24]);   mem[a2] = pte(f3, vm[1]);
        a3 = ea(f3, va[23:13]);   mem[a3] = pte(leaf, vm[2]);
    endtask

    // Run one walk and check its result, reads and handshakes
    task automatic run_walk(input logic [45:0] va, input logic [18:0] root,
                            input bit xf, input logic [1:0] xl, input logic [31:0] xpa,
                            input int xrd, input logic [31:0] a1, a2, a3,
                            input int stall, input int hold, input bit poke,
                            input string tag);
        int start;
        int t;
        logic [31:0] xa [3];
        xa[0] = a1; xa[1] = a2; xa[2] = a3;
        @(negedge clk);
        start = nrd;
        if (stall > 0) mem_req_ready = 1'b0;
        req_valid = 1'b1; req_vaddr = va; root_frame = root; rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R7 busy after accept"}, req_ready, 0);
        if (poke) begin
            req_valid = 1'b1; req_vaddr = ~va; root_frame = ~root;
        end
        for (int s = 0; s < stall; s++) begin
            chk(mem_req_valid && mem_req_addr == a1, {tag, " R6 stalled request held"},
                {mem_req_valid, mem_req_addr}, {1'b1, a1});
            @(negedge clk);
        end
        mem_req_ready = 1'b1;
        t = 0;
        while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
        if (poke) chk(req_ready == 1'b0, {tag, " R7 poke not taken"}, req_ready, 0);
        req_valid = 1'b0;
        chk(rsp_valid, {tag, " R4 response"}, rsp_valid, 1);
        chk(rsp_fault == xf, {tag, " R5 fault flag"}, rsp_fault, xf);
        chk(rsp_level == xl, {tag, " R9 level"}, rsp_level, xl);
        chk(rsp_paddr == xpa, {tag, " R4 paddr"}, rsp_paddr, xpa);
        chk(nrd - start == xrd, {tag, " R5 read count"}, nrd - start, xrd);
        for (int k = 0; k < xrd && k < 3; k++)
            chk(rd_log[(start + k) % 8] == xa[k], {tag, " R2 entry address"},
                rd_log[(start + k) % 8], xa[k]);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == xpa && rsp_fault == xf && rsp_level == xl,
                {tag, " R8 held response"}, {rsp_valid, rsp_paddr}, {1'b1, xpa});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, {tag, " R8 back to idle"}, {rsp_valid, req_ready}, 1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
    endtask

    task automatic t_ok(input logic [45:0] va, input logic [18:0] base,
                        input logic [18:0] leaf, input int stall, input int hold,
                        input bit poke, input string tag);
        logic [31:0] a1, a2, a3;
        map3(va, base, base + 19'd1, base + 19'd2, leaf, 3'b111, a1, a2, a3);
        run_walk(va, base, 1'b0, 2'd0, {leaf, va[12:0]}, 3, a1, a2, a3,
                 stall, hold, poke, tag);
    endtask

    task automatic t_fault(input int lvl, input logic [45:0] va,
                           input logic [18:0] base, input string tag);
        logic [31:0] a1, a2, a3;
        logic [2:0] vm;
        vm = 3'b111;
        vm[lvl-1] = 1'b0;
        map3(va, base, base + 19'd1, base + 19'd2, 19'h4_4444, vm, a1, a2, a3);
        run_walk(va, base, 1'b1, 2'(lvl), 32'h0, lvl, a1, a2, a3, 0, 0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ok(46'h1234_5678_9ABC, 19'h00010, 19'h7_ABCD, 0, 3, 1'b0, "plain");
        t_ok(46'h3FFF_FFFF_FFFF, 19'h00100, 19'h7_FFFF, 0, 0, 1'b0, "all-ones");
        t_ok(46'h0, 19'h00400, 19'h0_0001, 0, 0, 1'b0, "zero");
        t_fault(1, 46'h0ABC_DEF0_1234, 19'h01000, "fault-L1");
        t_fault(2, 46'h1555_AAAA_5555, 19'h01100, "fault-L2");
        t_fault(3, 46'h2AAA_5555_0FFF, 19'h01200, "fault-L3");
        t_ok(46'h0F0F_0F0F_1111, 19'h02000, 19'h1_2345, 4, 0, 1'b0, "stall");
        t_ok(46'h3030_4040_5050, 19'h03000, 19'h6_0606, 0, 1, 1'b1, "poke");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hang counts as a failed check
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule